// File: doc/BRIEF.md
# Packed Three-Operand Carry-Save Compressor

This block is a combinational 3:2 compressor. It takes three operand buses, which may have different widths, and widens each of them to a common width N. N is the largest of the three widths. One full adder sits at every bit position, and no carry passes between positions. The result is a single packed vector. Its lower half is the sum word and its upper half is the carry word shifted left by one place. A downstream carry-propagate adder, or the next compressor in a reduction tree, consumes that vector.

The `SIGNED` parameter selects how the block is used. In unsigned use, narrow operands are padded with zeros and the top filler bit of the sum word is 0. In signed use, both the padding and that filler bit are constant ones. The padding is not a copy of each operand's own sign bit. The packed result is always read as an unsigned quantity.

Top module: `csa3_compress`

## Requirements
- R1: N equals the largest of WA, WB and WC. The output `csa_o` is 2N+2 bits wide.
- R2: With SIGNED=0, each operand narrower than N is extended with zero bits up to N.
- R3: With SIGNED=1, each operand narrower than N is extended with one bits up to N, whatever the operand's top bit is.
- R4: For i in 0..N-1, `csa_o[i]` is the XOR of bit i of the three extended operands.
- R5: For i in 0..N-1, `csa_o[N+2+i]` is the majority of bit i of the three extended operands. No other bit position affects it.
- R6: `csa_o[N+1]`, the lowest bit of the carry word, is always 0.
- R7: `csa_o[N]`, the top bit of the sum word, equals SIGNED.
- R8: With SIGNED=0, `csa_o[N:0] + csa_o[2N+1:N+1]` equals a+b+c exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WA | First operand |
| b_i | input | WB | Second operand |
| c_i | input | WC | Third operand |
| csa_o | output | 2N+2 | Packed result: {carry word, sum word}, each N+1 bits |

## Verification
Two conditions are hard to reach from the ports. The first is the fill behaviour on the narrow operands, which only shows in the bit positions above an operand's own width. The second is the fact that no carry ripples, which only shows when several neighbouring positions produce a carry at once. The bench drives two instances with the same unequal widths (8, 5 and 6 bits), one unsigned and one signed. It applies all-zero, all-ones, walking-one and alternating patterns before a random sweep. In the signed instance, narrow operands whose top bit is 0 show that the ones fill comes from the mode and not from the operand.

// File: rtl/csa3_pkg.sv
package csa3_pkg;

  function automatic int max3(int x, int y, int z);
    int m;
    m = (x > y) ? x : y;
    return (m > z) ? m : z;
  endfunction

endpackage

// File: rtl/csa3_extend.sv
module csa3_extend #(
  parameter int W_IN  = 4,
  parameter int W_OUT = 8,
  parameter bit FILL  = 1'b0
) (
  input  logic [W_IN-1:0]  op_i,
  output logic [W_OUT-1:0] op_o
);

  localparam int W_PAD = W_OUT - W_IN;

  generate
    if (W_PAD == 0) begin : g_pass
      assign op_o = op_i;
    end else begin : g_pad
      // constant fill, not a copy of the operand's top bit
      assign op_o = {{W_PAD{FILL}}, op_i};
    end
  endgenerate

endmodule

// File: rtl/csa3_fa_row.sv
module csa3_fa_row #(
  parameter int N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  output logic [N-1:0] sum_o,
  output logic [N-1:0] cry_o
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_fa
      logic [1:0] cnt;
      assign cnt      = {1'b0, a_i[i]} + {1'b0, b_i[i]} + {1'b0, c_i[i]};
      assign sum_o[i] = cnt[0];
      assign cry_o[i] = cnt[1];

      always_comb begin
        a_r4_sum_parity: assert (sum_o[i] == (a_i[i] ^ b_i[i] ^ c_i[i]))
          else $error("sum bit %0d not parity of inputs", i);
        a_r5_carry_majority: assert (cry_o[i] ==
            ((a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i])))
          else $error("carry bit %0d not majority of inputs", i);
      end
    end
  endgenerate

endmodule

// File: rtl/csa3_pack.sv
module csa3_pack #(
  parameter int N    = 8,
  parameter bit FILL = 1'b0
) (
  input  logic [N-1:0]     sum_i,
  input  logic [N-1:0]     cry_i,
  output logic [2*N+1:0]   pack_o
);

  // upper half: carry word shifted up one; lower half: filler over sums
  assign pack_o = {cry_i, 1'b0, FILL, sum_i};

endmodule

// File: rtl/csa3_compress.sv
module csa3_compress
  import csa3_pkg::*;
#(
  parameter int WA     = 8,
  parameter int WB     = 5,
  parameter int WC     = 6,
  parameter bit SIGNED = 1'b0
) (
  input  logic [WA-1:0]                    a_i,
  input  logic [WB-1:0]                    b_i,
  input  logic [WC-1:0]                    c_i,
  output logic [2*max3(WA, WB, WC)+1:0]    csa_o
);

  localparam int N = max3(WA, WB, WC);

  logic [N-1:0] pa, pb, pc;
  logic [N-1:0] sum_w, cry_w;

  csa3_extend #(.W_IN(WA), .W_OUT(N), .FILL(SIGNED)) i_ext_a (.op_i(a_i), .op_o(pa));
  csa3_extend #(.W_IN(WB), .W_OUT(N), .FILL(SIGNED)) i_ext_b (.op_i(b_i), .op_o(pb));
  csa3_extend #(.W_IN(WC), .W_OUT(N), .FILL(SIGNED)) i_ext_c (.op_i(c_i), .op_o(pc));

  csa3_fa_row #(.N(N)) i_row (
    .a_i  (pa),
    .b_i  (pb),
    .c_i  (pc),
    .sum_o(sum_w),
    .cry_o(cry_w)
  );

  csa3_pack #(.N(N), .FILL(SIGNED)) i_pack (
    .sum_i (sum_w),
    .cry_i (cry_w),
    .pack_o(csa_o)
  );

  // arithmetic view of the packed output against the extended operands
  logic [N+1:0] lhs_tot, rhs_tot;
  assign lhs_tot = {2'b00, sum_w} + {1'b0, csa_o[2*N+1:N+1]};
  assign rhs_tot = {2'b00, pa} + {2'b00, pb} + {2'b00, pc};

  always_comb begin
    a_r6_carry_lsb_zero: assert (csa_o[N+1] == 1'b0)
      else $error("carry word bit 0 not zero");
    a_r7_sum_filler: assert (csa_o[N] == SIGNED)
      else $error("sum word top bit not equal to mode");
    a_r5_halves_total: assert (lhs_tot == rhs_tot)
      else $error("sum+carry %0d != operand total %0d", lhs_tot, rhs_tot);
    a_r8_unsigned_total: assert (SIGNED || ({1'b0, csa_o[N:0]} + {1'b0, csa_o[2*N+1:N+1]}
                                 == ({2'b00, a_i} + {2'b00, b_i} + {2'b00, c_i})))
      else $error("unsigned halves do not add to a+b+c");
  end

endmodule

// File: tb/test_csa3_compress.sv
module test_csa3_compress;

  localparam int CLK_PERIOD = 10;
  localparam int WA = 8;
  localparam int WB = 5;
  localparam int WC = 6;
  localparam int N  = 8;
  localparam int WO = 2 * N + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [WA-1:0] a;
  logic [WB-1:0] b;
  logic [WC-1:0] c;
  logic [WO-1:0] out_u, out_s;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  csa3_compress #(.WA(WA), .WB(WB), .WC(WC), .SIGNED(1'b0)) i_csa3_compress (
    .a_i(a), .b_i(b), .c_i(c), .csa_o(out_u));

  csa3_compress #(.WA(WA), .WB(WB), .WC(WC), .SIGNED(1'b1)) i_csa3_compress_signed (
    .a_i(a), .b_i(b), .c_i(c), .csa_o(out_s));

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: per-position count of ones, fill by mode
  function automatic logic [WO-1:0] model(input logic [WA-1:0] av, input logic [WB-1:0] bv,
                                          input logic [WC-1:0] cv, input bit sgn);
    logic [N:0] sw, cw;
    sw = '0;
    cw = '0;
    for (int k = 0; k < N; k++) begin
      int cnt;
      cnt = (k < WA ? int'(av[k]) : int'(sgn))
          + (k < WB ? int'(bv[k]) : int'(sgn))
          + (k < WC ? int'(cv[k]) : int'(sgn));
      sw[k]   = cnt[0];
      cw[k+1] = cnt[1];
    end
    sw[N] = sgn;
    return {cw, sw};
  endfunction

  task automatic apply(input logic [WA-1:0] av, input logic [WB-1:0] bv,
                       input logic [WC-1:0] cv);
    logic [WO-1:0] eu, es;
    int total, got;
    @(posedge clk);
    a = av; b = bv; c = cv;
    @(negedge clk);
    eu = model(av, bv, cv, 1'b0);
    es = model(av, bv, cv, 1'b1);
    check(out_u == eu, "R2 unsigned zero-extended word", 32'(out_u), 32'(eu));
    check(out_s == es, "R3 signed ones-extended word", 32'(out_s), 32'(es));
    check(out_u[N-1:0] == eu[N-1:0], "R4 sum bits", 32'(out_u[N-1:0]), 32'(eu[N-1:0]));
    check(out_u[WO-1:N+2] == eu[WO-1:N+2], "R5 carry bits",
          32'(out_u[WO-1:N+2]), 32'(eu[WO-1:N+2]));
    check(out_u[N+1] == 1'b0 && out_s[N+1] == 1'b0, "R6 carry lsb",
          32'({out_s[N+1], out_u[N+1]}), 32'(0));
    check(out_u[N] == 1'b0 && out_s[N] == 1'b1, "R7 sum filler",
          32'({out_s[N], out_u[N]}), 32'(2));
    total = int'(av) + int'(bv) + int'(cv);
    got   = int'(out_u[N:0]) + int'(out_u[WO-1:N+1]);
    check(got == total, "R8 halves add to a+b+c", 32'(got), 32'(total));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; c = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset/idle state: zero operands
    check(out_u == '0, "R7 idle unsigned output", 32'(out_u), 32'(0));
    check(out_s == model('0, '0, '0, 1'b1), "R3 idle signed output",
          32'(out_s), 32'(model('0, '0, '0, 1'b1)));
    check($bits(out_u) == WO, "R1 output width", 32'($bits(out_u)), 32'(WO));

    apply('0, '0, '0);
    apply('1, '1, '1);
    apply(8'hFF, 5'h00, 6'h00);
    apply(8'h00, 5'h1F, 6'h00);
    apply(8'h00, 5'h00, 6'h3F);
    apply(8'h55, 5'h0A, 6'h15);
    apply(8'hAA, 5'h15, 6'h2A);
    apply(8'h7F, 5'h0F, 6'h1F);  // narrow tops clear: signed fill still ones
    // R5 no ripple: generate carry at every position simultaneously
    apply(8'hFF, 5'h1F, 6'h00);
    for (int k = 0; k < N; k++) apply(8'(1 << k), 5'(1 << (k % WB)), 6'(1 << (k % WC)));
    for (int k = 0; k < 200; k++) apply(8'($urandom), 5'($urandom), 6'($urandom));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule